// File: doc/BRIEF.md
# Banked Video and Work Memory Controller

This block sits on an 8-bit CPU bus with a 16-bit address and serves two banked memories of a handheld console's memory map. Video memory appears in an 8 KiB window and is backed by two physical banks; work memory appears as a fixed 4 KiB window followed by a switchable 4 KiB window, backed by eight physical banks. Two select registers, reachable at I/O addresses, pick the bank seen through each banked window, and both can be read back.

Each access is one request qualified by a valid strobe. Writes take effect at the clock edge. Read data appears on the cycle after the request. The storage arrays are synchronous RAMs inside the block. The per-bank depth is a parameter. When it is set below the full window size, the window address wraps modulo the bank size. After reset a sweep writes zero to every video memory location. A busy output is high while the sweep runs.

Top module: `vwram_bank_ctrl`

## Requirements
- R1: A request to 0x8000–0x9FFF reaches video bank `vsel`. The location is `vsel * 2^VRAM_BANK_AW + (addr mod 2^VRAM_BANK_AW)`, so the two banks hold separate data. With the default VRAM_BANK_AW = 10, the addresses 0x8000 and 0x8400 reach the same location.
- R2: A write to 0xFF4F stores data bit 0 as `vsel`. A read of 0xFF4F returns 0xFE OR `vsel`.
- R3: Requests to 0xC000–0xCFFF always reach work bank 0. Requests to 0xD000–0xDFFF reach work bank `wsel`. The location is `bank * 2^WRAM_BANK_AW + (addr mod 2^WRAM_BANK_AW)`. The default WRAM_BANK_AW is 8.
- R4: A write to 0xFF70 stores data bits 2..0 as `wsel`, except that a value of 0 is stored as 1. A read of 0xFF70 returns 0xF8 OR `wsel`.
- R5: Reset sets `vsel` to 0 and `wsel` to 1. After reset, `clr_busy_o` is high while every video location is written with 0x00. While it is high, video writes are dropped and video reads return 0xFF.
- R6: A request to any other address reads 0xFF, and a write to such an address changes no memory and no select register.
- R7: `rdata_o` carries the data of a read issued in the previous cycle. Back-to-back reads each return their own data. In a cycle that follows no valid read, `rdata_o` is 0xFF.
- R8: A select write changes the bank used by the request in the very next cycle. Every access uses the single bank that is selected in its own cycle.
- R9: A request with `req_valid_i` low changes no memory or register and produces a read result of 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | CPU address |
| req_wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the request |
| clr_busy_o | output | 1 | Video memory clear sweep in progress |

## Verification
The bench builds the block with the default parameters, VRAM_BANK_AW = 10 and WRAM_BANK_AW = 8. With these shallow banks the post-reset clear sweep lasts 2048 cycles, so the bench can wait for it to finish, run a second reset and confirm that earlier data is gone. Address wrap within a bank is visible at two window addresses that are 1 KiB apart. Bank separation is tested by writing the same offset in different banks and reading each one back. The bench also switches banks on consecutive cycles to test the next-cycle rule.

// File: rtl/vwr_pkg.sv
package vwr_pkg;
  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_VRAM  = 3'd1,
    RG_WRAM0 = 3'd2,
    RG_WRAMX = 3'd3,
    RG_VSEL  = 3'd4,
    RG_WSEL  = 3'd5
  } region_e;

  localparam logic [15:0] VSEL_ADDR = 16'hFF4F;
  localparam logic [15:0] WSEL_ADDR = 16'hFF70;
  localparam logic [7:0]  OPEN_BUS  = 8'hFF;
endpackage

// File: rtl/vwr_decode.sv
module vwr_decode
  import vwr_pkg::*;
(
  input  logic [15:0] addr_i,
  output region_e     region_o
);
  always_comb begin
    region_o = RG_NONE;
    if (addr_i[15:13] == 3'b100)        region_o = RG_VRAM;
    else if (addr_i[15:12] == 4'hC)     region_o = RG_WRAM0;
    else if (addr_i[15:12] == 4'hD)     region_o = RG_WRAMX;
    else if (addr_i == VSEL_ADDR)       region_o = RG_VSEL;
    else if (addr_i == WSEL_ADDR)       region_o = RG_WSEL;
  end
endmodule

// File: rtl/vwr_bank_regs.sv
module vwr_bank_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vsel_we_i,
  input  logic       wsel_we_i,
  input  logic [2:0] wdata_i,
  output logic       vsel_o,
  output logic [2:0] wsel_o
);
  logic       vsel_q;
  logic [2:0] wsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsel_q <= 1'b0;
      wsel_q <= 3'd1;
    end else begin
      if (vsel_we_i) vsel_q <= wdata_i[0];
      if (wsel_we_i) wsel_q <= (wdata_i == 3'd0) ? 3'd1 : wdata_i;
    end
  end

  assign vsel_o = vsel_q;
  assign wsel_o = wsel_q;

  p_vsel_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsel_we_i |=> vsel_o == $past(wdata_i[0]));
  p_vsel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsel_we_i |=> $stable(vsel_o));
  p_wsel_zero_remap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsel_we_i && wdata_i == 3'd0) |=> wsel_o == 3'd1);
  p_wsel_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wsel_we_i |=> $stable(wsel_o));
endmodule

// File: rtl/vwr_ram.sv
module vwr_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/vwram_bank_ctrl.sv
module vwram_bank_ctrl
  import vwr_pkg::*;
#(
  parameter int unsigned VRAM_BANK_AW = 10,
  parameter int unsigned WRAM_BANK_AW = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_we_i,
  input  logic [15:0] req_addr_i,
  input  logic [7:0]  req_wdata_i,
  output logic [7:0]  rdata_o,
  output logic        clr_busy_o
);
  localparam int unsigned VRAM_AW = VRAM_BANK_AW + 1;
  localparam int unsigned WRAM_AW = WRAM_BANK_AW + 3;
  localparam logic [VRAM_AW-1:0] CLR_LAST = '1;

  region_e region;
  logic    vsel;
  logic [2:0] wsel;

  vwr_decode u_decode (
    .addr_i   (req_addr_i),
    .region_o (region)
  );

  // Video memory clear sweep after reset
  logic               clr_busy_q;
  logic [VRAM_AW-1:0] clr_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_busy_q <= 1'b1;
      clr_idx_q  <= '0;
    end else if (clr_busy_q) begin
      clr_idx_q <= clr_idx_q + 1'b1;
      if (clr_idx_q == CLR_LAST) clr_busy_q <= 1'b0;
    end
  end
  assign clr_busy_o = clr_busy_q;

  // Effective region: video accesses are dropped during the sweep
  region_e region_eff;
  always_comb begin
    region_eff = RG_NONE;
    if (req_valid_i) begin
      region_eff = region;
      if (clr_busy_q && region == RG_VRAM) region_eff = RG_NONE;
    end
  end

  logic wr_req;
  assign wr_req = req_valid_i && req_we_i;

  vwr_bank_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vsel_we_i (wr_req && region_eff == RG_VSEL),
    .wsel_we_i (wr_req && region_eff == RG_WSEL),
    .wdata_i   (req_wdata_i[2:0]),
    .vsel_o    (vsel),
    .wsel_o    (wsel)
  );

  // Video memory port
  logic               vram_en, vram_we;
  logic [VRAM_AW-1:0] vram_addr;
  logic [7:0]         vram_wdata, vram_rdata;

  always_comb begin
    if (clr_busy_q) begin
      vram_en    = 1'b1;
      vram_we    = 1'b1;
      vram_addr  = clr_idx_q;
      vram_wdata = 8'h00;
    end else begin
      vram_en    = region_eff == RG_VRAM;
      vram_we    = req_we_i;
      vram_addr  = {vsel, req_addr_i[VRAM_BANK_AW-1:0]};
      vram_wdata = req_wdata_i;
    end
  end

  vwr_ram #(.AW(VRAM_AW), .DW(8)) u_vram (
    .clk_i   (clk_i),
    .en_i    (vram_en),
    .we_i    (vram_we),
    .addr_i  (vram_addr),
    .wdata_i (vram_wdata),
    .rdata_o (vram_rdata)
  );

  // Work memory port
  logic               wram_en;
  logic [2:0]         wram_bank;
  logic [WRAM_AW-1:0] wram_addr;
  logic [7:0]         wram_rdata;

  assign wram_en   = (region_eff == RG_WRAM0) || (region_eff == RG_WRAMX);
  assign wram_bank = (region_eff == RG_WRAMX) ? wsel : 3'd0;
  assign wram_addr = {wram_bank, req_addr_i[WRAM_BANK_AW-1:0]};

  vwr_ram #(.AW(WRAM_AW), .DW(8)) u_wram (
    .clk_i   (clk_i),
    .en_i    (wram_en),
    .we_i    (req_we_i),
    .addr_i  (wram_addr),
    .wdata_i (req_wdata_i),
    .rdata_o (wram_rdata)
  );

  // Read return path, one cycle
  region_e    rsel_q;
  logic [7:0] regval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q   <= RG_NONE;
      regval_q <= OPEN_BUS;
    end else begin
      rsel_q <= (req_valid_i && !req_we_i) ? region_eff : RG_NONE;
      if (region_eff == RG_VSEL) regval_q <= {7'h7F, vsel};
      else                       regval_q <= {5'h1F, wsel};
    end
  end

  always_comb begin
    case (rsel_q)
      RG_VRAM:                rdata_o = vram_rdata;
      RG_WRAM0, RG_WRAMX:     rdata_o = wram_rdata;
      RG_VSEL, RG_WSEL:       rdata_o = regval_q;
      default:                rdata_o = OPEN_BUS;
    endcase
  end

  p_unmapped_ff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && region == RG_NONE) |=> rdata_o == OPEN_BUS);
  p_idle_ff_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> rdata_o == OPEN_BUS);
  p_clr_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_busy_q && req_valid_i && !req_we_i && region == RG_VRAM) |=> rdata_o == OPEN_BUS);
  p_clr_done_stays_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clr_busy_q) |=> !clr_busy_q);
  p_vsel_read_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && region == RG_VSEL) |=> rdata_o[7:1] == 7'h7F);
endmodule

// File: tb/vwram_bank_ctrl_bench.sv
module vwram_bank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vwram_bank_ctrl u_vwram_bank_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (valid),
    .req_we_i    (we),
    .req_addr_i  (addr),
    .req_wdata_i (wdata),
    .rdata_o     (rdata),
    .clr_busy_o  (busy)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    valid = 1'b0;
  endtask

  task automatic wait_clear();
    int n = 0;
    while (busy === 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R5 busy after reset", {7'h0, busy}, 8'h01);
    chk("R7 idle rdata", rdata, 8'hFF);
    rd(16'hFF4F, d); chk("R5/R2 vsel reset", d, 8'hFE);
    rd(16'hFF70, d); chk("R5/R4 wsel reset", d, 8'hF9);
    rd(16'h8010, d); chk("R5 vram read during clear", d, 8'hFF);
    wait_clear();
    chk("R5 busy drops", {7'h0, busy}, 8'h00);
  endtask

  task automatic t_vram_banks();
    logic [7:0] d;
    wr(16'hFF4F, 8'h00); wr(16'h8123, 8'hA5);
    wr(16'hFF4F, 8'hFF); wr(16'h8123, 8'h5A);
    rd(16'hFF4F, d); chk("R2 vsel readback 1", d, 8'hFF);
    rd(16'h8123, d); chk("R1 bank1 data", d, 8'h5A);
    wr(16'hFF4F, 8'h02);
    rd(16'hFF4F, d); chk("R2 only bit0 kept", d, 8'hFE);
    rd(16'h8123, d); chk("R1 bank0 data", d, 8'hA5);
    wr(16'h9C00, 8'h3C);
    rd(16'h8000, d); chk("R1 window wrap", d, 8'h3C);
  endtask

  task automatic t_wram_banks();
    logic [7:0] d;
    wr(16'hC010, 8'hC0);
    wr(16'hFF70, 8'h03); wr(16'hD010, 8'h33);
    wr(16'hFF70, 8'hFD); wr(16'hD010, 8'h55);
    rd(16'hFF70, d); chk("R4 low 3 bits kept", d, 8'hFD);
    wr(16'hFF70, 8'h03);
    rd(16'hD010, d); chk("R3 bank3 data", d, 8'h33);
    rd(16'hC010, d); chk("R3 fixed window bank0", d, 8'hC0);
    wr(16'hFF70, 8'h08);
    rd(16'hFF70, d); chk("R4 zero remapped to 1", d, 8'hF9);
    wr(16'hD010, 8'h11);
    rd(16'hC010, d); chk("R4 bank1 not bank0", d, 8'hC0);
    rd(16'hD010, d); chk("R4 bank1 data", d, 8'h11);
    wr(16'hFF70, 8'h05);
    rd(16'hD010, d); chk("R3 bank5 data", d, 8'h55);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(16'h8040, 8'h77);
    wr(16'hA040, 8'h12); wr(16'hFF4E, 8'h01); wr(16'hFF71, 8'h00);
    rd(16'hA040, d); chk("R6 unmapped read", d, 8'hFF);
    rd(16'hE010, d); chk("R6 unmapped read echo", d, 8'hFF);
    rd(16'h8040, d); chk("R6 vram untouched", d, 8'h77);
    rd(16'hFF4F, d); chk("R6 vsel untouched", d, 8'hFE);
    rd(16'hFF70, d); chk("R6 wsel untouched", d, 8'hFD);
  endtask

  task automatic t_latency();
    logic [7:0] d1, d2;
    wr(16'h8001, 8'h01); wr(16'h8002, 8'h02);
    @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = 16'h8001;
    @(negedge clk);
    d1 = rdata; addr = 16'h8002;
    @(negedge clk);
    d2 = rdata; valid = 1'b0;
    @(negedge clk);
    chk("R7 b2b first", d1, 8'h01);
    chk("R7 b2b second", d2, 8'h02);
    chk("R7 idle after reads", rdata, 8'hFF);
  endtask

  task automatic t_switch_next();
    logic [7:0] d;
    @(negedge clk);
    valid = 1'b1; we = 1'b1; addr = 16'hFF4F; wdata = 8'h01;
    @(negedge clk);
    addr = 16'h8005; wdata = 8'hAA;
    @(negedge clk);
    addr = 16'hFF4F; wdata = 8'h00;
    @(negedge clk);
    addr = 16'h8005; wdata = 8'h55;
    @(negedge clk);
    we = 1'b0; addr = 16'h8005;
    @(negedge clk);
    d = rdata; valid = 1'b0;
    chk("R8 bank0 next cycle", d, 8'h55);
    wr(16'hFF4F, 8'h01);
    rd(16'h8005, d); chk("R8 bank1 next cycle", d, 8'hAA);
    wr(16'hFF4F, 8'h00);
  endtask

  task automatic t_valid_gate();
    logic [7:0] d;
    @(negedge clk);
    valid = 1'b0; we = 1'b1; addr = 16'hFF4F; wdata = 8'h01;
    @(negedge clk);
    addr = 16'h8005; wdata = 8'hEE;
    @(negedge clk);
    we = 1'b0;
    chk("R9 no read without valid", rdata, 8'hFF);
    rd(16'hFF4F, d); chk("R9 vsel unchanged", d, 8'hFE);
    rd(16'h8005, d); chk("R9 vram unchanged", d, 8'h55);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    do_reset();
    wr(16'h8005, 8'h99);
    wait_clear();
    rd(16'h8005, d); chk("R5 write during clear dropped", d, 8'h00);
    rd(16'h8040, d); chk("R5 bank0 cleared", d, 8'h00);
    wr(16'hFF4F, 8'h01);
    rd(16'h8005, d); chk("R5 bank1 cleared", d, 8'h00);
    rd(16'hFF70, d); chk("R5 wsel back to 1", d, 8'hF9);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_vram_banks();
        t_wram_banks();
        t_unmapped();
        t_latency();
        t_switch_next();
        t_valid_gate();
        t_clear();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule